// File: doc/BRIEF.md
# Dual-Bus Parallel Host Register Port

This block is the host-facing register port of a character display controller. A host processor reaches it over a parallel bus made of a register-select line, two control lines and an 8-bit data bus. A static strap input picks how the two control lines are read. In one style they are an enable strobe and a read/write level. In the other they are two active-low strobes, one for read and one for write. All bus pins are sampled inside the single system-clock domain through synchroniser flops. Each access is therefore seen as an edge or a level on synchronised copies of the pins.

Completed writes reach the internal controller as a one-cycle instruction pulse or data pulse, together with the byte. Reads present either the status word (busy flag and address counter) or the controller's data register. The read data is driven only while the read strobe is active, and it comes with an output-enable for the pad. The port starts in full 8-bit width. A function-set instruction can switch it to a 4-bit bus, where every byte moves in two nibbles on the upper four data lines, high nibble first. An external active-low reset line is filtered by pulse width. A long enough low pulse re-initialises the port, and the controller is told through a pulse.

Top module: `hostport_dualbus`

## Requirements
- R1: A completed write with `bus_rs` low produces a one-cycle `cmd_wr` pulse with the written byte on `wr_byte`.
- R2: A completed write with `bus_rs` high produces a one-cycle `dat_wr` pulse with the written byte on `wr_byte`.
- R3: During a read strobe `bus_oe` is 1. With `bus_rs` low, `bus_dout` shows {`ctl_busy`, `ctl_addr`}, with the busy flag on bit 7. With `bus_rs` high it shows `ctl_rdata`. Outside a read `bus_oe` is 0.
- R4: With `strap_intel`=0, `bus_ctl_b` is an active-high enable and `bus_ctl_a` is a read/write level (1 = read), and a write is committed on the falling edge of the enable. With `strap_intel`=1, `bus_ctl_a` is an active-low write strobe committed on its rising edge, and `bus_ctl_b` is an active-low read strobe.
- R5: After reset `wide_mode` is 1 (8-bit bus). An instruction byte whose bits 7..5 are 001 sets `wide_mode` to its bit 4. No other byte changes the width.
- R6: With `wide_mode`=0 a byte takes two write accesses. Bits 7..4 of the first give the upper nibble and bits 7..4 of the second give the lower nibble. `bus_din[3:0]` is ignored, and only the second access yields a pulse.
- R7: With `wide_mode`=0 a byte read takes two accesses. `bus_dout[7:4]` carries the upper nibble and then the lower nibble, and `bus_dout[3:0]` is 0. Both halves come from one word captured at the start of the upper-nibble access.
- R8: `rd_done` pulses once per completed byte read, after the read strobe ends. In 8-bit mode this is every access, and in 4-bit mode only the second. `rd_rs` gives the register selected.
- R9: A low on `ext_rst_n` lasting fewer than `RST_MIN_CYC`-2 clock cycles has no effect. A low lasting `RST_MIN_CYC` cycles or more gives one `init_req` pulse and returns `wide_mode` to 1.
- R10: The nibble phase returns to upper on reset, on `init_req` and on any width change, so the next access after one of these is an upper nibble.
- R11: `cmd_wr` and `dat_wr` are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_rst_n | input | 1 | External active-low reset line, pulse-width filtered |
| strap_intel | input | 1 | Static bus-style strap: 0 enable+R/W style, 1 separate strobes |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_ctl_a | input | 1 | R/W level (strap 0) or active-low write strobe (strap 1) |
| bus_ctl_b | input | 1 | Enable strobe (strap 0) or active-low read strobe (strap 1) |
| bus_din | input | 8 | Data bus input |
| bus_dout | output | 8 | Data bus read value, 0 when not driving |
| bus_oe | output | 1 | Tri-state enable for the data bus pads |
| ctl_busy | input | 1 | Busy flag from the controller |
| ctl_addr | input | 7 | Address counter from the controller |
| ctl_rdata | input | 8 | Data register contents from the controller |
| cmd_wr | output | 1 | One-cycle instruction byte strobe |
| dat_wr | output | 1 | One-cycle data byte strobe |
| wr_byte | output | 8 | Byte belonging to the last write strobe |
| rd_done | output | 1 | One-cycle pulse after a completed byte read |
| rd_rs | output | 1 | Register select of the completed read |
| init_req | output | 1 | One-cycle re-initialisation request from a long external reset |
| wide_mode | output | 1 | Current bus width: 1 for 8-bit, 0 for 4-bit |

## Verification
The bench builds the port with two synchroniser stages and `RST_MIN_CYC` lowered to 16. The short limit makes both sides of the reset-width threshold cheap to reach: a glitch of 12 cycles and a pulse of 20. Random instruction and data bytes, with random status and data-register values, run under both strap settings and both bus widths. The low data lines carry random garbage during nibble accesses. The register values are changed between the two halves of a 4-bit read to show that the captured word holds. A dangling upper nibble across a filtered glitch and across a real reset shows that the nibble phase survives the first and is cleared by the second.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int HP_DW = 8;
  localparam int HP_NW = HP_DW / 2;
  localparam int HP_AW = HP_DW - 1;
  localparam logic [2:0] FNSET_TAG = 3'b001;

  function automatic logic fnset_hit(input logic [HP_DW-1:0] b);
    return b[HP_DW-1 -: 3] == FNSET_TAG;
  endfunction

  function automatic logic fnset_wide(input logic [HP_DW-1:0] b);
    return b[HP_NW];
  endfunction

  function automatic logic [HP_DW-1:0] status_word(input logic busy, input logic [HP_AW-1:0] addr);
    return {busy, addr};
  endfunction

  function automatic logic [HP_DW-1:0] nib_present(input logic [HP_DW-1:0] w, input logic lower);
    return lower ? {w[HP_NW-1:0], {HP_NW{1'b0}}} : {w[HP_DW-1:HP_NW], {HP_NW{1'b0}}};
  endfunction

  function automatic logic [HP_DW-1:0] nib_join(input logic [HP_NW-1:0] hi, input logic [HP_DW-1:0] bus);
    return {hi, bus[HP_DW-1:HP_NW]};
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hp_rstflt.sv
module hp_rstflt #(
  parameter int STAGES = 2,
  parameter int MIN_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst_n,
  output logic init_req
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic          ext_s;
  logic          ext_low;
  logic [CW-1:0] low_cnt;

  hp_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(ext_s)
  );

  assign ext_low = !ext_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      init_req <= 1'b0;
    end else begin
      init_req <= ext_low && (low_cnt == CW'(MIN_CYC - 1));
      if (!ext_low)                     low_cnt <= '0;
      else if (low_cnt != CW'(MIN_CYC)) low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hp_strobe.sv
module hp_strobe
  import hp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_intel,
  input  logic             bus_rs,
  input  logic             bus_ctl_a,
  input  logic             bus_ctl_b,
  input  logic [HP_DW-1:0] bus_din,
  output logic             evt_wr,
  output logic             evt_rd_start,
  output logic             evt_rd_end,
  output logic             rd_act,
  output logic             ev_rs,
  output logic [HP_DW-1:0] ev_din
);
  localparam int PW = HP_DW + 3;

  logic [PW-1:0] pins_s;
  logic          a_s, b_s, a_q, b_q;
  logic          rd_act_q;
  logic [STAGES:0] arm_sh;
  logic          armed;
  logic          wr_edge, rd_lvl;

  hp_sync #(.W(PW), .STAGES(STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_rs, bus_ctl_a, bus_ctl_b, bus_din}), .q(pins_s)
  );

  assign ev_rs  = pins_s[PW-1];
  assign a_s    = pins_s[PW-2];
  assign b_s    = pins_s[PW-3];
  assign ev_din = pins_s[HP_DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= 1'b0;
      b_q      <= 1'b0;
      rd_act_q <= 1'b0;
      arm_sh   <= '0;
    end else begin
      a_q      <= a_s;
      b_q      <= b_s;
      rd_act_q <= rd_act;
      arm_sh   <= {arm_sh[STAGES-1:0], 1'b1};
    end
  end

  assign armed = arm_sh[STAGES];

  always_comb begin
    if (strap_intel) begin
      wr_edge = !a_q && a_s;
      rd_lvl  = !b_s;
    end else begin
      wr_edge = b_q && !b_s && !a_s;
      rd_lvl  = b_s && a_s;
    end
  end

  assign evt_wr       = armed && wr_edge;
  assign rd_act       = armed && rd_lvl;
  assign evt_rd_start = rd_act && !rd_act_q;
  assign evt_rd_end   = !rd_act && rd_act_q;
endmodule

// File: rtl/hp_xfer.sv
module hp_xfer
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             evt_wr,
  input  logic             evt_rd_start,
  input  logic             evt_rd_end,
  input  logic             rd_act,
  input  logic             ev_rs,
  input  logic [HP_DW-1:0] ev_din,
  input  logic             ctl_busy,
  input  logic [HP_AW-1:0] ctl_addr,
  input  logic [HP_DW-1:0] ctl_rdata,
  output logic             cmd_wr,
  output logic             dat_wr,
  output logic [HP_DW-1:0] wr_byte,
  output logic             rd_done,
  output logic             rd_rs,
  output logic [HP_DW-1:0] bus_dout,
  output logic             bus_oe,
  output logic             wide_mode,
  output logic             phase_lo
);
  logic [HP_NW-1:0] hi_hold;
  logic [HP_DW-1:0] snap;
  logic             full_hit;
  logic [HP_DW-1:0] full_byte;
  logic             wide_nxt;
  logic             phase_nxt;

  assign full_hit  = evt_wr && (wide_mode || phase_lo);
  assign full_byte = wide_mode ? ev_din : nib_join(hi_hold, ev_din);

  always_comb begin
    wide_nxt = wide_mode;
    if (full_hit && !ev_rs && fnset_hit(full_byte)) wide_nxt = fnset_wide(full_byte);
    phase_nxt = phase_lo;
    if (!wide_mode && (evt_wr || evt_rd_end)) phase_nxt = !phase_lo;
    if (wide_nxt != wide_mode) phase_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr    <= 1'b0;
      dat_wr    <= 1'b0;
      wr_byte   <= '0;
      rd_done   <= 1'b0;
      rd_rs     <= 1'b0;
      bus_oe    <= 1'b0;
      wide_mode <= 1'b1;
      phase_lo  <= 1'b0;
      hi_hold   <= '0;
      snap      <= '0;
    end else begin
      cmd_wr  <= 1'b0;
      dat_wr  <= 1'b0;
      rd_done <= 1'b0;
      bus_oe  <= rd_act;
      if (init_req) begin
        wide_mode <= 1'b1;
        phase_lo  <= 1'b0;
      end else begin
        wide_mode <= wide_nxt;
        phase_lo  <= phase_nxt;
        if (evt_wr && !wide_mode && !phase_lo) hi_hold <= ev_din[HP_DW-1:HP_NW];
        if (full_hit) begin
          cmd_wr  <= !ev_rs;
          dat_wr  <= ev_rs;
          wr_byte <= full_byte;
        end
        if (evt_rd_start && (wide_mode || !phase_lo))
          snap <= ev_rs ? ctl_rdata : status_word(ctl_busy, ctl_addr);
        if (evt_rd_end && (wide_mode || phase_lo)) begin
          rd_done <= 1'b1;
          rd_rs   <= ev_rs;
        end
      end
    end
  end

  assign bus_dout = !bus_oe ? '0 : (wide_mode ? snap : nib_present(snap, phase_lo));
endmodule

// File: rtl/hostport_dualbus.sv
module hostport_dualbus
  import hp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_n,
  input  logic             strap_intel,
  input  logic             bus_rs,
  input  logic             bus_ctl_a,
  input  logic             bus_ctl_b,
  input  logic [HP_DW-1:0] bus_din,
  output logic [HP_DW-1:0] bus_dout,
  output logic             bus_oe,
  input  logic             ctl_busy,
  input  logic [HP_AW-1:0] ctl_addr,
  input  logic [HP_DW-1:0] ctl_rdata,
  output logic             cmd_wr,
  output logic             dat_wr,
  output logic [HP_DW-1:0] wr_byte,
  output logic             rd_done,
  output logic             rd_rs,
  output logic             init_req,
  output logic             wide_mode
);
  logic             evt_wr;
  logic             evt_rd_start;
  logic             evt_rd_end;
  logic             rd_act;
  logic             ev_rs;
  logic [HP_DW-1:0] ev_din;
  logic             phase_lo;

  hp_rstflt #(.STAGES(SYNC_STAGES), .MIN_CYC(RST_MIN_CYC)) u_rf (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .init_req(init_req)
  );

  hp_strobe #(.STAGES(SYNC_STAGES)) u_st (
    .clk(clk), .rst_n(rst_n), .strap_intel(strap_intel),
    .bus_rs(bus_rs), .bus_ctl_a(bus_ctl_a), .bus_ctl_b(bus_ctl_b), .bus_din(bus_din),
    .evt_wr(evt_wr), .evt_rd_start(evt_rd_start), .evt_rd_end(evt_rd_end),
    .rd_act(rd_act), .ev_rs(ev_rs), .ev_din(ev_din)
  );

  hp_xfer u_xf (
    .clk(clk), .rst_n(rst_n), .init_req(init_req),
    .evt_wr(evt_wr), .evt_rd_start(evt_rd_start), .evt_rd_end(evt_rd_end),
    .rd_act(rd_act), .ev_rs(ev_rs), .ev_din(ev_din),
    .ctl_busy(ctl_busy), .ctl_addr(ctl_addr), .ctl_rdata(ctl_rdata),
    .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wr_byte(wr_byte),
    .rd_done(rd_done), .rd_rs(rd_rs), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .wide_mode(wide_mode), .phase_lo(phase_lo)
  );
endmodule

// File: rtl/hp_chk.sv
module hp_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic dat_wr,
  input logic bus_oe,
  input logic rd_done,
  input logic init_req,
  input logic wide_mode,
  input logic phase_lo,
  input logic evt_wr,
  input logic evt_rd_end
);
  // R11
  excl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_wr && dat_wr));
  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr |=> !cmd_wr);
  // R11
  dat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) dat_wr |=> !dat_wr);
  // R8
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> $past(evt_rd_end));
  // R3
  done_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> !bus_oe);
  // R5
  width_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode != $past(wide_mode)) |-> (cmd_wr || $past(init_req)));
  // R9
  init_wide_chk: assert property (@(posedge clk) disable iff (!rst_n) init_req |=> (wide_mode && !phase_lo));
  // R10
  phase_wide_chk: assert property (@(posedge clk) disable iff (!rst_n) wide_mode |-> !phase_lo);
  // R6
  lower_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && phase_lo && !init_req) |=> (cmd_wr || dat_wr));
endmodule

bind hostport_dualbus hp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .bus_oe(bus_oe),
  .rd_done(rd_done), .init_req(init_req), .wide_mode(wide_mode), .phase_lo(phase_lo),
  .evt_wr(evt_wr), .evt_rd_end(evt_rd_end)
);

// File: tb/sim_hostport_dualbus.sv
module sim_hostport_dualbus;
  localparam int CLK_PERIOD = 10;
  localparam int RST_MIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst_n = 1'b1;
  logic strap_intel = 1'b0;
  logic bus_rs = 1'b0;
  logic bus_ctl_a = 1'b1;
  logic bus_ctl_b = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic bus_oe;
  logic ctl_busy = 1'b0;
  logic [6:0] ctl_addr = 7'h00;
  logic [7:0] ctl_rdata = 8'h00;
  logic cmd_wr, dat_wr, rd_done, rd_rs, init_req, wide_mode;
  logic [7:0] wr_byte;

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_dat = 0, n_done = 0, n_init = 0;
  logic [7:0] last_wr = 8'h00;
  logic last_rs = 1'b0;
  logic exp_wide = 1'b1;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_dualbus #(.SYNC_STAGES(2), .RST_MIN_CYC(RST_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .strap_intel(strap_intel),
    .bus_rs(bus_rs), .bus_ctl_a(bus_ctl_a), .bus_ctl_b(bus_ctl_b), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .ctl_busy(ctl_busy), .ctl_addr(ctl_addr),
    .ctl_rdata(ctl_rdata), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .wr_byte(wr_byte),
    .rd_done(rd_done), .rd_rs(rd_rs), .init_req(init_req), .wide_mode(wide_mode)
  );

  always @(negedge clk) if (rst_n) begin
    if (cmd_wr) begin n_cmd++; last_wr = wr_byte; end
    if (dat_wr) begin n_dat++; last_wr = wr_byte; end
    if (rd_done) begin n_done++; last_rs = rd_rs; end
    if (init_req) n_init++;
  end

  function automatic logic [7:0] exp_half(input logic [7:0] w, input bit lower);
    logic [7:0] r;
    r = lower ? (w << 4) : w;
    return r & 8'hF0;
  endfunction

  function automatic bit is_width_cmd(input logic [7:0] b);
    return (b >> 5) == 8'd1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc_wr(input logic rs, input logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_din = d;
    if (!strap_intel) begin
      bus_ctl_a = 1'b0;
      repeat (2) @(negedge clk); bus_ctl_b = 1'b1;
      repeat (4) @(negedge clk); bus_ctl_b = 1'b0;
      repeat (4) @(negedge clk); bus_ctl_a = 1'b1;
    end else begin
      repeat (2) @(negedge clk); bus_ctl_a = 1'b0;
      repeat (4) @(negedge clk); bus_ctl_a = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic acc_rd(input logic rs, output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_rs = rs;
    if (!strap_intel) begin
      bus_ctl_a = 1'b1;
      repeat (2) @(negedge clk); bus_ctl_b = 1'b1;
      repeat (6) @(negedge clk); d = bus_dout; oe = bus_oe; bus_ctl_b = 1'b0;
    end else begin
      repeat (2) @(negedge clk); bus_ctl_b = 1'b0;
      repeat (6) @(negedge clk); d = bus_dout; oe = bus_oe; bus_ctl_b = 1'b1;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic host_wr(input logic rs, input logic [7:0] b);
    int c0, d0;
    string tag;
    c0 = n_cmd; d0 = n_dat;
    tag = !exp_wide ? "R6 nibble write" : (rs ? "R2 data write" : "R1 instr write");
    if (exp_wide) acc_wr(rs, b);
    else begin
      acc_wr(rs, {b[7:4], 4'($urandom)});
      check("R6 no pulse after upper nibble", n_cmd + n_dat - c0 - d0, 0);
      acc_wr(rs, {b[3:0], 4'($urandom)});
    end
    repeat (2) @(negedge clk);
    if (rs) check({tag, " dat count"}, n_dat - d0, 1);
    else    check({tag, " cmd count"}, n_cmd - c0, 1);
    check("R11 exactly one strobe", n_cmd + n_dat - c0 - d0, 1);
    check({tag, " byte"}, last_wr, b);
    if (!rs && is_width_cmd(b)) begin
      exp_wide = b[4];
      check("R5 width from function set", wide_mode, exp_wide);
    end
  endtask

  task automatic host_rd(input logic rs);
    logic [7:0] exp, g1, g2;
    logic oe1, oe2;
    int dn0;
    ctl_busy = 1'($urandom); ctl_addr = 7'($urandom); ctl_rdata = 8'($urandom);
    exp = rs ? ctl_rdata : {ctl_busy, ctl_addr};
    dn0 = n_done;
    if (exp_wide) begin
      acc_rd(rs, g1, oe1);
      check("R3 read word", g1, exp);
      check("R3 oe during read", oe1, 1);
    end else begin
      acc_rd(rs, g1, oe1);
      check("R8 no done after upper nibble", n_done - dn0, 0);
      ctl_busy = ~ctl_busy; ctl_addr = ~ctl_addr; ctl_rdata = ~ctl_rdata;
      acc_rd(rs, g2, oe2);
      check("R7 upper nibble", g1, exp_half(exp, 0));
      check("R7 lower nibble from captured word", g2, exp_half(exp, 1));
      check("R3 oe during nibble reads", oe1 & oe2, 1);
    end
    check("R8 one done per byte", n_done - dn0, 1);
    check("R8 done register select", last_rs, rs);
    check("R3 oe off after read", bus_oe, 0);
    check("R3 dout idle zero", bus_dout, 0);
  endtask

  task automatic sys_reset(input logic intel);
    @(negedge clk);
    rst_n = 1'b0; strap_intel = intel;
    bus_ctl_a = 1'b1; bus_ctl_b = intel ? 1'b1 : 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; exp_wide = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic ext_pulse(input int cyc);
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (cyc) @(negedge clk); ext_rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rand_mix(input int n);
    for (int i = 0; i < n; i++) begin
      logic rs;
      logic [7:0] b;
      rs = 1'($urandom);
      b = 8'($urandom);
      if ($urandom % 3 == 0) host_rd(rs);
      else host_wr(rs, b);
    end
  endtask

  initial begin
    int c0, i0;
    void'($urandom(32'd1234));
    sys_reset(1'b0);
    check("R5 reset width", wide_mode, 1);
    check("R3 reset oe", bus_oe, 0);
    check("R3 reset dout", bus_dout, 0);
    check("R11 no strobe at reset", n_cmd + n_dat, 0);

    // R4 enable + R/W style, 8-bit then 4-bit
    c0 = n_cmd + n_dat;
    host_wr(1'b0, 8'h01);
    host_wr(1'b1, 8'hA5);
    host_rd(1'b0);
    host_rd(1'b1);
    rand_mix(10);
    host_wr(1'b0, 8'h2C);
    host_wr(1'b1, 8'h3C);
    host_rd(1'b1);
    host_rd(1'b0);
    rand_mix(10);
    check("R4 enable-style writes seen", (n_cmd + n_dat - c0) > 0, 1);

    // R4 separate-strobe style
    sys_reset(1'b1);
    check("R5 width after reset in strobe style", wide_mode, 1);
    host_wr(1'b0, 8'h80);
    host_rd(1'b0);
    rand_mix(10);
    host_wr(1'b0, 8'h20);
    host_wr(1'b1, 8'h5A);
    host_rd(1'b1);
    rand_mix(10);
    host_wr(1'b0, 8'h30);
    check("R5 back to 8-bit", wide_mode, 1);

    // R9 glitch ignored, R10 phase kept then cleared
    host_wr(1'b0, 8'h24);
    c0 = n_dat; i0 = n_init;
    acc_wr(1'b1, 8'hC7);
    ext_pulse(RST_MIN - 4);
    check("R9 short low ignored", n_init - i0, 0);
    check("R9 width kept after glitch", wide_mode, 0);
    acc_wr(1'b1, 8'h3F);
    repeat (2) @(negedge clk);
    check("R9 pending nibble kept over glitch", last_wr, 8'hC3);
    check("R6 pair after glitch", n_dat - c0, 1);
    acc_wr(1'b1, 8'h90);
    ext_pulse(RST_MIN + 4);
    exp_wide = 1'b1;
    check("R9 long low gives one init", n_init - i0, 1);
    check("R9 width restored", wide_mode, 1);
    host_wr(1'b1, 8'h6E);
    host_wr(1'b0, 8'h28);
    host_wr(1'b1, 8'hB4);
    check("R10 nibble phase realigned", last_wr, 8'hB4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule